// File: doc/BRIEF.md
# Aligned Storage Transfer Segmenter

This block copies a run of bytes between a byte-addressed storage port and a 256-byte channel data buffer. A request names the first storage byte, a byte count from 1 to 256, a starting offset in the buffer and a direction. The block cuts the run into storage segments that never cross a 64-byte aligned boundary. A segment is shorter than 64 bytes only where the storage run starts or ends off such a boundary.

Both sides are 8 bytes wide. Storage is touched one aligned 8-byte word per beat, and each beat carries a byte-enable mask. The buffer is accessed as 32 words of 8 bytes each. Because the storage offset and the buffer offset may differ, a byte shifter rotates every beat by that difference modulo 8. A residue register carries the bytes that spill into the neighbouring buffer word over to the next beat.

A transfer toward storage first reads one buffer word to fill the residue. A transfer from storage ends with one flush cycle that writes any bytes still held in the residue. A one-cycle completion pulse marks the end of every transfer.

Top module: `storage_xfer_seg`

## Requirements
- R1: A start is taken only while `busy` is low. A start raised during a transfer is ignored and leaves that transfer, its data and its single `done` pulse unchanged.
- R2: A start with `count` equal to 0 or greater than 256 raises `err` for exactly one cycle, in the cycle after the start. It produces no storage beat, no `done` and no `busy`.
- R3: Storage beats present 8-byte aligned addresses in ascending order. The first beat is at `saddr` rounded down to a multiple of 8, and there is one beat per 8-byte word the run touches. Bit i of `st_be` enables byte `st_addr+i`, and it is set exactly when that byte lies in [`saddr`, `saddr+count`).
- R4: `st_sop` marks the first beat of each 64-byte aligned storage block the run touches, and `st_eop` marks the last beat inside that block. Each signal is therefore seen once per segment.
- R5: With `dir`=1 (buffer to storage, `st_we`=1), storage byte `saddr+k` receives buffer byte (`baddr+k`) mod 256 for every k below `count`. No other storage byte is written.
- R6: With `dir`=0 (storage to buffer), buffer byte (`baddr+k`) mod 256 receives storage byte `saddr+k` for every k below `count`. No other buffer byte is written.
- R7: Buffer addressing wraps modulo 256. A run that passes buffer byte 255 continues at buffer byte 0.
- R8: While `st_valid` is high and `st_ready` is low, the beat holds: `st_valid`, `st_addr`, `st_be`, `st_sop`, `st_eop` and (for `dir`=1) `st_wdata` stay unchanged until the beat is accepted.
- R9: `done` is high for exactly one cycle, after the final storage beat is accepted (or after the flush cycle when `dir`=0). `busy` is low in the cycle after `done`.
- R10: After reset, `busy`, `done`, `err`, `st_valid`, `buf_re` and `buf_we` are low. `st_valid`, `buf_re` and `buf_we` stay low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a transfer |
| dir | input | 1 | 1: buffer to storage, 0: storage to buffer |
| saddr | input | ADDR_W | First storage byte address |
| baddr | input | 8 | First buffer byte offset |
| count | input | 9 | Byte count, legal 1..256 |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle illegal-count pulse |
| st_valid | output | 1 | Storage beat offered |
| st_ready | input | 1 | Storage accepts the beat |
| st_we | output | 1 | Beat writes storage |
| st_addr | output | ADDR_W | Aligned word address of the beat |
| st_be | output | 8 | Byte enables of the beat |
| st_wdata | output | 64 | Write data toward storage |
| st_rdata | input | 64 | Read data, valid in the accept cycle |
| st_sop | output | 1 | First beat of a segment |
| st_eop | output | 1 | Last beat of a segment |
| buf_addr | output | 5 | Buffer word index |
| buf_re | output | 1 | Buffer read strobe |
| buf_rdata | input | 64 | Buffer word, valid in the same cycle |
| buf_we | output | 1 | Buffer write strobe |
| buf_be | output | 8 | Buffer byte enables |
| buf_wdata | output | 64 | Buffer write data |

## Verification
Segmenting and shifting collide when the beat that closes a 64-byte segment is also the beat whose bytes straddle two buffer words. On that beat, the residue must carry the spilled bytes past the segment edge without loss. The vectors provoke this with storage and buffer offsets that differ modulo 8, with runs that cross one or more 64-byte boundaries and the buffer wrap, and with `st_ready` dropped on every third cycle so that such a beat is also stalled. The result is judged by comparing every byte of both memories against the address arithmetic of R5 and R6, and by counting the segment markers against the number of blocks touched.

// File: rtl/sts_pkg.sv
package sts_pkg;
    localparam int BEAT_B = 8;
    localparam int LANE_W = $clog2(BEAT_B);
    localparam int DATA_W = BEAT_B * 8;
    localparam int SEG_B  = 64;
    localparam int SEG_W  = $clog2(SEG_B);
    localparam int BUF_B  = 256;
    localparam int BUF_AW = $clog2(BUF_B);
    localparam int BUF_WW = BUF_AW - LANE_W;
    localparam int CNT_W  = BUF_AW + 1;

    typedef logic [LANE_W-1:0] lane_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [BEAT_B-1:0] mask_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRIME,
        PH_BEAT,
        PH_FLUSH,
        PH_DONE
    } phase_e;

    typedef struct packed {
        word_t data;
        mask_t be;
    } lanes_t;

    // lane k of the result takes lane (k - s) mod BEAT_B of the input
    function automatic lanes_t rotate_up(lanes_t x, lane_t s);
        lanes_t y;
        lane_t  src;
        for (int k = 0; k < BEAT_B; k++) begin
            src = lane_t'(k) - s;
            y.data[k*8 +: 8] = x.data[int'(src)*8 +: 8];
            y.be[k]          = x.be[src];
        end
        return y;
    endfunction

    // eight consecutive bytes of {hi, lo} starting at byte s of lo
    function automatic word_t extract_span(word_t lo, word_t hi, lane_t s);
        logic [2*DATA_W-1:0] both;
        both = {hi, lo} >> (int'(s) * 8);
        return both[DATA_W-1:0];
    endfunction

    function automatic logic range_error(logic [CNT_W-1:0] n);
        return (n == '0) || (n > CNT_W'(BUF_B));
    endfunction
endpackage

// File: rtl/sts_seg_walker.sv
module sts_seg_walker
    import sts_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              adv,
    input  logic [ADDR_W-1:0] saddr,
    input  logic [CNT_W-1:0]  count,
    output logic [ADDR_W-1:0] beat_addr,
    output mask_t             beat_be,
    output logic              seg_first,
    output logic              seg_last,
    output logic              xfer_last
);
    localparam int EW = ADDR_W + 1;

    logic [ADDR_W-1:0] cur_q;
    logic              first_q;
    logic [EW-1:0]     lo_q;
    logic [EW-1:0]     hi_q;
    logic [EW-1:0]     nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q   <= '0;
            first_q <= 1'b0;
            lo_q    <= '0;
            hi_q    <= '0;
        end else if (load) begin
            cur_q   <= {saddr[ADDR_W-1:LANE_W], LANE_W'(0)};
            first_q <= 1'b1;
            lo_q    <= {1'b0, saddr};
            hi_q    <= {1'b0, saddr} + EW'(count);
        end else if (adv) begin
            cur_q   <= cur_q + ADDR_W'(BEAT_B);
            first_q <= 1'b0;
        end
    end

    assign nxt = {1'b0, cur_q} + EW'(BEAT_B);

    always_comb begin
        logic [EW-1:0] a;
        for (int k = 0; k < BEAT_B; k++) begin
            a          = {1'b0, cur_q} + EW'(k);
            beat_be[k] = (a >= lo_q) && (a < hi_q);
        end
    end

    assign beat_addr = cur_q;
    assign xfer_last = (nxt >= hi_q);
    assign seg_first = first_q || (cur_q[SEG_W-1:0] == '0);
    assign seg_last  = xfer_last || (nxt[SEG_W-1:0] == '0);

    // a beat that ends a segment is followed by one that starts a segment
    AST_SEG_CHAIN: assert property (@(posedge clk) disable iff (rst)
        (adv && seg_last && !xfer_last) |=> seg_first); // R4
endmodule

// File: rtl/sts_lane_shifter.sv
module sts_lane_shifter
    import sts_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  load_res,
    input  logic  merge_adv,
    input  lane_t shift,
    input  word_t st_rdata,
    input  mask_t st_be,
    input  word_t buf_rdata,
    output word_t st_wdata,
    output word_t buf_wdata,
    output mask_t buf_be
);
    word_t  res_data_q;
    mask_t  res_be_q;
    lanes_t raw;
    lanes_t rot;
    word_t  res_data_nxt;
    mask_t  res_be_nxt;

    assign raw.data = st_rdata;
    assign raw.be   = st_be;
    assign rot      = rotate_up(raw, shift);

    // toward storage: residue holds buffer word j, read port gives word j+1
    assign st_wdata = extract_span(res_data_q, buf_rdata, shift);

    // toward buffer: low lanes come from the residue, upper lanes from this beat
    always_comb begin
        for (int k = 0; k < BEAT_B; k++) begin
            if (k < int'(shift)) begin
                buf_wdata[k*8 +: 8]    = res_data_q[k*8 +: 8];
                buf_be[k]              = res_be_q[k];
                res_data_nxt[k*8 +: 8] = rot.data[k*8 +: 8];
                res_be_nxt[k]          = rot.be[k];
            end else begin
                buf_wdata[k*8 +: 8]    = rot.data[k*8 +: 8];
                buf_be[k]              = rot.be[k];
                res_data_nxt[k*8 +: 8] = 8'h00;
                res_be_nxt[k]          = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            res_data_q <= '0;
            res_be_q   <= '0;
        end else if (load_res) begin
            res_data_q <= buf_rdata;
            res_be_q   <= '0;
        end else if (merge_adv) begin
            res_data_q <= res_data_nxt;
            res_be_q   <= res_be_nxt;
        end
    end

    // with no shift nothing may spill into the residue
    AST_NO_SPILL: assert property (@(posedge clk) disable iff (rst)
        (merge_adv && shift == '0) |=> (res_be_q == '0)); // R6
endmodule

// File: rtl/storage_xfer_seg.sv
module storage_xfer_seg
    import sts_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                dir,
    input  logic [ADDR_W-1:0]   saddr,
    input  logic [BUF_AW-1:0]   baddr,
    input  logic [CNT_W-1:0]    count,
    output logic                busy,
    output logic                done,
    output logic                err,
    output logic                st_valid,
    input  logic                st_ready,
    output logic                st_we,
    output logic [ADDR_W-1:0]   st_addr,
    output logic [BEAT_B-1:0]   st_be,
    output logic [DATA_W-1:0]   st_wdata,
    input  logic [DATA_W-1:0]   st_rdata,
    output logic                st_sop,
    output logic                st_eop,
    output logic [BUF_WW-1:0]   buf_addr,
    output logic                buf_re,
    input  logic [DATA_W-1:0]   buf_rdata,
    output logic                buf_we,
    output logic [BEAT_B-1:0]   buf_be,
    output logic [DATA_W-1:0]   buf_wdata
);
    phase_e            ph_q;
    logic              dir_q;
    lane_t             shift_q;
    logic [BUF_WW-1:0] widx_q;
    logic              err_q;

    logic              accept;
    logic              take;
    logic              bad;
    logic              load;
    logic [BUF_AW-1:0] lane0;
    logic              xfer_last;
    mask_t             be_int;
    mask_t             buf_be_int;

    assign accept = st_valid && st_ready;
    assign take   = (ph_q == PH_IDLE) && start;
    assign bad    = range_error(count);
    assign load   = take && !bad;
    // buffer byte position of storage lane 0 of the first beat
    assign lane0  = baddr - BUF_AW'(saddr[LANE_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= PH_IDLE;
            dir_q   <= 1'b0;
            shift_q <= '0;
            widx_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= take && bad;
            case (ph_q)
                PH_IDLE: begin
                    if (load) begin
                        dir_q   <= dir;
                        shift_q <= lane0[LANE_W-1:0];
                        widx_q  <= lane0[BUF_AW-1:LANE_W];
                        ph_q    <= dir ? PH_PRIME : PH_BEAT;
                    end
                end
                PH_PRIME: ph_q <= PH_BEAT;
                PH_BEAT: begin
                    if (accept) begin
                        widx_q <= widx_q + BUF_WW'(1);
                        if (xfer_last) ph_q <= dir_q ? PH_DONE : PH_FLUSH;
                    end
                end
                PH_FLUSH: ph_q <= PH_DONE;
                PH_DONE:  ph_q <= PH_IDLE;
                default:  ph_q <= PH_IDLE;
            endcase
        end
    end

    sts_seg_walker #(.ADDR_W(ADDR_W)) u_walk (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .adv       (accept),
        .saddr     (saddr),
        .count     (count),
        .beat_addr (st_addr),
        .beat_be   (be_int),
        .seg_first (st_sop),
        .seg_last  (st_eop),
        .xfer_last (xfer_last)
    );

    sts_lane_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .clear     (load),
        .load_res  ((ph_q == PH_PRIME) || (ph_q == PH_BEAT && dir_q && accept)),
        .merge_adv (ph_q == PH_BEAT && !dir_q && accept),
        .shift     (shift_q),
        .st_rdata  (st_rdata),
        .st_be     (be_int),
        .buf_rdata (buf_rdata),
        .st_wdata  (st_wdata),
        .buf_wdata (buf_wdata),
        .buf_be    (buf_be_int)
    );

    assign st_be    = be_int;
    assign buf_be   = buf_be_int;
    assign st_valid = (ph_q == PH_BEAT);
    assign st_we    = dir_q;
    assign buf_re   = (ph_q == PH_PRIME) || (ph_q == PH_BEAT && dir_q);
    assign buf_addr = (ph_q == PH_BEAT && dir_q) ? widx_q + BUF_WW'(1) : widx_q;
    assign buf_we   = !dir_q && (|buf_be_int) &&
                      ((ph_q == PH_BEAT && accept) || ph_q == PH_FLUSH);
    assign busy     = (ph_q != PH_IDLE);
    assign done     = (ph_q == PH_DONE);
    assign err      = err_q;

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st_valid && !st_ready) |=> (st_valid && $stable(st_addr) && $stable(st_be)
                                     && $stable(st_sop) && $stable(st_eop))); // R8
    AST_BEAT_LIVE: assert property (@(posedge clk) disable iff (rst)
        st_valid |-> (st_be != '0)); // R3
    AST_DONE_ONCE: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy)); // R9
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
        err |-> (!busy && !st_valid)); // R2
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!st_valid && !buf_we && !buf_re)); // R10
    AST_IGNORE_START: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !done) |=> busy); // R1
endmodule

// File: tb/tb_storage_xfer_seg.sv
module tb_storage_xfer_seg;
    import sts_pkg::*;

    localparam int AW   = 16;
    localparam int SMEM = 1024;
    localparam int NV   = 8;

    typedef struct packed {
        logic [15:0] sa;
        logic [7:0]  ba;
        logic [8:0]  n;
        logic        d;
        logic        stall;
        logic [3:0]  segs;
        logic [5:0]  beats;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{16'h0000, 8'h00, 9'd64,  1'b1, 1'b0, 4'd1, 6'd8},
        '{16'h0045, 8'h03, 9'd100, 1'b0, 1'b1, 4'd2, 6'd14},
        '{16'h0010, 8'hFA, 9'd256, 1'b1, 1'b1, 4'd5, 6'd32},
        '{16'h003F, 8'h80, 9'd2,   1'b0, 1'b0, 4'd2, 6'd2},
        '{16'h0105, 8'h11, 9'd7,   1'b1, 1'b0, 4'd1, 6'd2},
        '{16'h0200, 8'hF9, 9'd200, 1'b0, 1'b1, 4'd4, 6'd25},
        '{16'h02C3, 8'h05, 9'd1,   1'b1, 1'b0, 4'd1, 6'd1},
        '{16'h0080, 8'h40, 9'd256, 1'b0, 1'b1, 4'd4, 6'd32}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic          dir;
    logic [AW-1:0] saddr;
    logic [7:0]    baddr;
    logic [8:0]    count;
    logic          busy, done, err;
    logic          st_valid, st_ready, st_we, st_sop, st_eop;
    logic [AW-1:0] st_addr;
    logic [7:0]    st_be;
    logic [63:0]   st_wdata, st_rdata;
    logic [4:0]    buf_addr;
    logic          buf_re, buf_we;
    logic [63:0]   buf_rdata, buf_wdata;
    logic [7:0]    buf_be;

    always #10 clk = ~clk;

    storage_xfer_seg #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .start(start), .dir(dir), .saddr(saddr),
        .baddr(baddr), .count(count), .busy(busy), .done(done), .err(err),
        .st_valid(st_valid), .st_ready(st_ready), .st_we(st_we),
        .st_addr(st_addr), .st_be(st_be), .st_wdata(st_wdata),
        .st_rdata(st_rdata), .st_sop(st_sop), .st_eop(st_eop),
        .buf_addr(buf_addr), .buf_re(buf_re), .buf_rdata(buf_rdata),
        .buf_we(buf_we), .buf_be(buf_be), .buf_wdata(buf_wdata)
    );

    int n_checks = 0;
    int n_err    = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] spat(int i, int sd);
        return 8'(i * 7 + sd * 13 + 3);
    endfunction
    function automatic logic [7:0] bpat(int i, int sd);
        return 8'(i * 11 + sd * 5 + 90);
    endfunction

    // storage and buffer models
    logic [7:0] smem [SMEM];
    logic [7:0] bmem [256];
    logic       init_req = 1'b0;
    int         seed = 0;
    logic       stall_mode = 1'b0;
    int         cyc = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        st_ready <= !stall_mode || (cyc % 3 != 1);
        if (init_req) begin
            for (int i = 0; i < SMEM; i++) smem[i] <= spat(i, seed);
            for (int i = 0; i < 256; i++)  bmem[i] <= bpat(i, seed);
        end else begin
            if (st_valid && st_ready && st_we)
                for (int k = 0; k < 8; k++)
                    if (st_be[k]) smem[(int'(st_addr) + k) % SMEM] <= st_wdata[k*8 +: 8];
            if (buf_we)
                for (int k = 0; k < 8; k++)
                    if (buf_be[k]) bmem[int'({buf_addr, 3'b000}) + k] <= buf_wdata[k*8 +: 8];
        end
    end

    always_comb begin
        for (int k = 0; k < 8; k++) begin
            st_rdata[k*8 +: 8]  = smem[(int'(st_addr) + k) % SMEM];
            buf_rdata[k*8 +: 8] = bmem[int'({buf_addr, 3'b000}) + k];
        end
    end

    // monitor, samples on the falling edge
    logic mon_clr = 1'b0;
    int   cur_sa = 0, cur_n = 0, cur_d = 0;
    int   beats, be_total, sops, eops, beat_err, hold_err;
    int   done_cnt, done_err, err_cnt, valid_seen, busy_seen, late_act;
    int   exp_addr;
    bit   hold_pend, done_prev, after_done;
    logic [AW-1:0] h_addr;
    logic [7:0]    h_be;
    logic [63:0]   h_wd;
    logic          h_sop, h_eop;

    always @(negedge clk) begin
        if (mon_clr) begin
            beats = 0; be_total = 0; sops = 0; eops = 0; beat_err = 0; hold_err = 0;
            done_cnt = 0; done_err = 0; err_cnt = 0; valid_seen = 0; busy_seen = 0;
            late_act = 0; exp_addr = cur_sa & ~7; hold_pend = 0; done_prev = 0;
            after_done = 0;
        end else begin
            logic [7:0] eb;
            if (hold_pend) begin
                if (!st_valid || st_addr != h_addr || st_be != h_be ||
                    st_sop != h_sop || st_eop != h_eop || (cur_d != 0 && st_wdata != h_wd))
                    hold_err++;
            end
            hold_pend = st_valid && !st_ready;
            h_addr = st_addr; h_be = st_be; h_wd = st_wdata; h_sop = st_sop; h_eop = st_eop;
            if (st_valid) valid_seen++;
            if (busy) busy_seen++;
            if (err) err_cnt++;
            if (after_done && (st_valid || busy)) late_act++;
            if (done_prev && busy) done_err++;
            done_prev = done;
            if (done) begin done_cnt++; after_done = 1; end
            if (st_valid && st_ready) begin
                beats++;
                be_total += $countones(st_be);
                if (st_sop) sops++;
                if (st_eop) eops++;
                if (int'(st_addr) != exp_addr) beat_err++;
                for (int k = 0; k < 8; k++)
                    eb[k] = (exp_addr + k >= cur_sa) && (exp_addr + k < cur_sa + cur_n);
                if (st_be != eb) beat_err++;
                exp_addr += 8;
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic prepare(input int sd, input int sa, input int n, input int d,
                           input bit stl);
        seed = sd; cur_sa = sa; cur_n = n; cur_d = d; stall_mode = stl;
        init_req = 1'b1; mon_clr = 1'b1;
        step();
        init_req = 1'b0; mon_clr = 1'b0;
        step();
    endtask

    task automatic run_vec(input vec_t v, input int sd, input bit intrude);
        int w;
        int bad_in, bad_out;
        prepare(sd, int'(v.sa), int'(v.n), int'(v.d), v.stall);
        start = 1'b1; dir = v.d; saddr = v.sa; baddr = v.ba; count = v.n;
        step();
        start = 1'b0;
        if (intrude) begin
            step(); step();
            start = 1'b1; dir = !v.d; saddr = 16'h0000; baddr = 8'h00; count = 9'd8;
            step();
            start = 1'b0;
        end
        w = 0;
        while (done_cnt == 0 && w < 3000) begin step(); w++; end
        repeat (10) step();
        bad_in = 0; bad_out = 0;
        if (v.d) begin
            for (int o = 0; o < int'(v.n); o++)
                if (smem[int'(v.sa) + o] != bpat((int'(v.ba) + o) % 256, sd)) bad_in++;
            for (int i = 0; i < SMEM; i++)
                if ((i < int'(v.sa) || i >= int'(v.sa) + int'(v.n)) && smem[i] != spat(i, sd))
                    bad_out++;
            check(bad_in == 0, "R5", "storage bytes copied from buffer (R7 wrap)", bad_in, 0);
            check(bad_out == 0, "R5", "storage bytes outside run untouched", bad_out, 0);
        end else begin
            for (int o = 0; o < int'(v.n); o++)
                if (bmem[(int'(v.ba) + o) % 256] != spat(int'(v.sa) + o, sd)) bad_in++;
            for (int j = 0; j < 256; j++)
                if (((j - int'(v.ba) + 256) % 256) >= int'(v.n) && bmem[j] != bpat(j, sd))
                    bad_out++;
            check(bad_in == 0, "R6", "buffer bytes copied from storage (R7 wrap)", bad_in, 0);
            check(bad_out == 0, "R6", "buffer bytes outside run untouched", bad_out, 0);
        end
        check(beats == int'(v.beats), "R3", "beat count", beats, int'(v.beats));
        check(beat_err == 0, "R3", "beat address or byte-enable mismatches", beat_err, 0);
        check(be_total == int'(v.n), "R3", "enabled bytes", be_total, int'(v.n));
        check(sops == int'(v.segs), "R4", "segment starts", sops, int'(v.segs));
        check(eops == int'(v.segs), "R4", "segment ends", eops, int'(v.segs));
        check(hold_err == 0, "R8", "stalled beat changed", hold_err, 0);
        check(done_cnt == 1, "R9", "done pulses", done_cnt, 1);
        check(done_err == 0, "R9", "busy after done", done_err, 0);
        check(late_act == 0, "R1", "activity after done", late_act, 0);
    endtask

    task automatic run_bad(input int n);
        prepare(9, 0, 0, 1, 1'b0);
        start = 1'b1; dir = 1'b1; saddr = 16'h0008; baddr = 8'h00; count = 9'(n);
        step();
        start = 1'b0;
        check(err == 1'b1, "R2", "err in cycle after start", int'(err), 1);
        step();
        check(err == 1'b0, "R2", "err width one cycle", int'(err), 0);
        repeat (6) step();
        check(err_cnt == 1, "R2", "err pulses", err_cnt, 1);
        check(valid_seen == 0 && busy_seen == 0 && done_cnt == 0, "R2",
              "beats, busy or done after bad count", valid_seen + busy_seen + done_cnt, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; dir = 1'b0; saddr = '0; baddr = '0; count = '0;
        st_ready = 1'b1;
        repeat (4) step();
        rst = 1'b0;
        step();
        // R10 reset state
        check(!busy && !done && !err, "R10", "status after reset",
              int'(busy) + int'(done) + int'(err), 0);
        check(!st_valid && !buf_re && !buf_we, "R10", "strobes after reset",
              int'(st_valid) + int'(buf_re) + int'(buf_we), 0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i + 1, 1'b0);

        // R2 illegal counts
        run_bad(0);
        run_bad(257);

        // R1 start during a transfer is ignored
        run_vec(VECS[1], 20, 1'b1);
        run_vec(VECS[2], 21, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end
endmodule